// File: doc/BRIEF.md
# Single-Bus CPU Control Sequencer

This block is the control unit and datapath of a very small processor in which every internal register hangs off one shared bus. It holds an instruction pointer, a memory address latch, a memory data latch, an instruction latch, an ALU operand latch, an ALU result latch and a small register file. A state machine walks each instruction through a fixed series of register transfers, one per clock. In each step it picks the single source that drives the bus and raises the load enables of the registers that take the bus value.

The memory sits outside the block, behind a plain port. The address always comes from the address latch and write data always comes from the data latch. Read data is latched into the data latch in the same step that the read strobe is high. Memory writes are applied at the clock edge that ends the write step. A parameter selects a two-bus variant, in which the ALU bridges the two buses and an add saves one step.

Top module: `sbus_cpu`

## Requirements
- R1: While reset is low (sampled synchronously), both memory strobes are low, the memory address is 0 and all registers clear to 0. The first step after reset release is the first step of an instruction, and its fetch reads address 0.
- R2: An instruction word is 12 bits: opcode in bits 11:9, destination register in 8:7, first source in 6:5, second source in 4:3, memory address in 3:0. The opcodes are 1 = LOAD, 2 = STORE, 3 = ADD and 4 = JMP.
- R3: Every instruction starts with four fetch steps. The fetch read occurs in step 1, at the current instruction pointer. The pointer then advances by one, so instructions that do not jump are fetched from consecutive addresses.
- R4: LOAD copies the memory word at the address field into the destination register. It performs its data read in step 5 and lasts 7 steps.
- R5: STORE writes the destination-field register to the address field. The write strobe is high in step 6, with that address and that data, and the instruction lasts 7 steps.
- R6: ADD sets the destination to first source plus second source, modulo 2^12, and lasts 7 steps in the one-bus build. The destination may equal either source.
- R7: JMP makes the next fetch come from the address field and lasts 5 steps.
- R8: Opcodes 0, 5, 6 and 7 change no register and no memory word, and last 4 steps.
- R9: In every step the controller selects exactly one bus source. An idle code counts as a source.
- R10: The memory is reached only through the address and data latches. Read and write never happen in the same step. A write is always preceded by a data-latch load from the bus, and the address is held over the write.
- R11: The instruction pointer wraps from 15 to 0.
- R12: In the two-bus build, ADD lasts 6 steps with the same result, and all other instructions keep their lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 4 | Memory address, from the address latch |
| mem_rd | output | 1 | Memory read strobe; data captured at the end of the step |
| mem_wr | output | 1 | Memory write strobe; write applied at the end of the step |
| mem_wdata | output | 12 | Write data, from the data latch |
| mem_rdata | input | 12 | Read data, combinational from memory |

## Verification
The bench runs the one-bus and two-bus builds side by side and compares every memory read and write against an instruction-level model. Each access must match in step number, address and data, so an off-by-one step count in any instruction class moves all later events and shows up at once. Self-modifying programs, adds that overflow or alias their sources, an instruction pointer that wraps past 15, and stores that follow the undefined opcodes catch, in turn: a stale instruction latch, a truncated or wrongly routed sum, a pointer that saturates, and a no-op that writes a register.

// File: rtl/sbc_pkg.sv
`timescale 1ns/1ps
// Shared types for the single-bus sequencer.
// Assumes a 3-bit opcode and a one-hot bus-source code.
package sbc_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OPC_LOAD  = 3'd1,
        OPC_STORE = 3'd2,
        OPC_ADD   = 3'd3,
        OPC_JMP   = 3'd4
    } opcode_e;

    // One-hot bus source; SRC_IDLE drives zero.
    typedef enum logic [5:0] {
        SRC_IDLE = 6'b000001,
        SRC_IP   = 6'b000010,
        SRC_IRA  = 6'b000100,
        SRC_MDR  = 6'b001000,
        SRC_REG  = 6'b010000,
        SRC_C    = 6'b100000
    } bus_src_e;

    // Instruction field that addresses the register-file read port.
    typedef enum logic [1:0] {
        FLD_DST  = 2'd0,
        FLD_SRCJ = 2'd1,
        FLD_SRCK = 2'd2
    } rd_fld_e;

    typedef enum logic [3:0] {
        ST_F0, ST_F1, ST_F2, ST_DEC,
        ST_L0, ST_L1, ST_L2,
        ST_S0, ST_S1, ST_S2,
        ST_A0, ST_A1, ST_A2,
        ST_J0
    } step_e;

    typedef struct packed {
        bus_src_e src;
        rd_fld_e  rd_fld;
        logic     ld_mar;
        logic     ld_mdr_mem;
        logic     ld_mdr_bus;
        logic     ld_ir;
        logic     ld_ip;
        logic     inc_ip;
        logic     ld_a;
        logic     ld_c;
        logic     wr_reg;
        logic     wr_from_alu;
        logic     mem_rd;
        logic     mem_wr;
    } ctl_t;

endpackage

// File: rtl/sbc_ctrl.sv
`timescale 1ns/1ps
// Step sequencer: walks fetch, decode and each execute series,
// one register transfer per clock.
// Assumes the opcode input comes from the instruction latch, loaded in ST_F2.
module sbc_ctrl
    import sbc_pkg::*;
#(
    parameter bit TWO_BUS = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] op,
    output ctl_t            ctl
);

    step_e step_q, step_d;

    // Step register, synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= ST_F0;
        else        step_q <= step_d;
    end

    // Control word and next step for the current step.
    always_comb begin
        ctl        = '0;
        ctl.src    = SRC_IDLE;
        ctl.rd_fld = FLD_DST;
        step_d     = ST_F0;
        case (step_q)
            ST_F0:  begin ctl.src = SRC_IP;  ctl.ld_mar = 1'b1; step_d = ST_F1; end
            ST_F1:  begin ctl.mem_rd = 1'b1; ctl.ld_mdr_mem = 1'b1; ctl.inc_ip = 1'b1; step_d = ST_F2; end
            ST_F2:  begin ctl.src = SRC_MDR; ctl.ld_ir = 1'b1; step_d = ST_DEC; end
            ST_DEC: begin
                case (op)
                    OPC_LOAD:  step_d = ST_L0;
                    OPC_STORE: step_d = ST_S0;
                    OPC_ADD:   step_d = ST_A0;
                    OPC_JMP:   step_d = ST_J0;
                    default:   step_d = ST_F0;
                endcase
            end
            ST_L0:  begin ctl.src = SRC_IRA; ctl.ld_mar = 1'b1; step_d = ST_L1; end
            ST_L1:  begin ctl.mem_rd = 1'b1; ctl.ld_mdr_mem = 1'b1; step_d = ST_L2; end
            ST_L2:  begin ctl.src = SRC_MDR; ctl.wr_reg = 1'b1; end
            ST_S0:  begin ctl.src = SRC_IRA; ctl.ld_mar = 1'b1; step_d = ST_S1; end
            ST_S1:  begin ctl.src = SRC_REG; ctl.rd_fld = FLD_DST; ctl.ld_mdr_bus = 1'b1; step_d = ST_S2; end
            ST_S2:  begin ctl.mem_wr = 1'b1; end
            ST_A0:  begin ctl.src = SRC_REG; ctl.rd_fld = FLD_SRCK; ctl.ld_a = 1'b1; step_d = ST_A1; end
            ST_A1:  begin
                ctl.src    = SRC_REG;
                ctl.rd_fld = FLD_SRCJ;
                if (TWO_BUS) begin
                    ctl.wr_reg      = 1'b1;
                    ctl.wr_from_alu = 1'b1;
                end else begin
                    ctl.ld_c = 1'b1;
                    step_d   = ST_A2;
                end
            end
            ST_A2:  begin ctl.src = SRC_C;   ctl.wr_reg = 1'b1; end
            ST_J0:  begin ctl.src = SRC_IRA; ctl.ld_ip = 1'b1; end
            default: step_d = ST_F0;
        endcase
    end

endmodule

// File: rtl/sbc_regfile.sv
`timescale 1ns/1ps
// General register file: one read port feeding the bus, one write port.
// Assumes NREG is a power of two.
module sbc_regfile #(
    parameter int DATA_W = 12,
    parameter int NREG   = 4,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] regs_q [NREG];

    // Register storage with synchronous clear.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n)                               regs_q[i] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(i)))  regs_q[i] <= wr_data;
        end
    end

    // Read port.
    assign rd_data = regs_q[rd_idx];

endmodule

// File: rtl/sbc_alu.sv
`timescale 1ns/1ps
// Adder between operand latch A and the bus (B input).
// Assumes modular wrap at DATA_W bits.
module sbc_alu #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum
);

    // Modular sum.
    assign sum = a + b;

endmodule

// File: rtl/sbus_cpu.sv
`timescale 1ns/1ps
// Single-bus CPU: datapath latches, bus multiplexer and the sequencer.
// Assumes DATA_W leaves room for the opcode and three register fields,
// and ADDR_W <= DATA_W. Memory is external and read combinationally.
module sbus_cpu
    import sbc_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int ADDR_W  = 4,
    parameter int NREG    = 4,
    parameter bit TWO_BUS = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int IDX_W  = $clog2(NREG);
    localparam int OP_LSB = DATA_W - OP_W;
    localparam int RI_LSB = OP_LSB - IDX_W;
    localparam int RJ_LSB = RI_LSB - IDX_W;
    localparam int RK_LSB = RJ_LSB - IDX_W;
    localparam int PAD_W  = DATA_W - ADDR_W;

    ctl_t              ctl;
    logic [ADDR_W-1:0] ip_q, mar_q;
    logic [DATA_W-1:0] mdr_q, ir_q, a_q, c_q;
    logic [DATA_W-1:0] bus, rf_rd, alu_sum, wr_data;
    logic [IDX_W-1:0]  rd_idx;

    // Plain copies of control fields for the bound checker.
    logic [5:0] bus_sel;
    logic       ld_mar_w, ld_mdr_bus_w;
    assign bus_sel      = ctl.src;
    assign ld_mar_w     = ctl.ld_mar;
    assign ld_mdr_bus_w = ctl.ld_mdr_bus;

    sbc_ctrl #(.TWO_BUS(TWO_BUS)) ctrl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (ir_q[OP_LSB +: OP_W]),
        .ctl   (ctl)
    );

    // Register-file read index from the selected instruction field.
    always_comb begin
        case (ctl.rd_fld)
            FLD_SRCJ: rd_idx = ir_q[RJ_LSB +: IDX_W];
            FLD_SRCK: rd_idx = ir_q[RK_LSB +: IDX_W];
            default:  rd_idx = ir_q[RI_LSB +: IDX_W];
        endcase
    end

    sbc_regfile #(.DATA_W(DATA_W), .NREG(NREG)) rf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rd_idx),
        .rd_data (rf_rd),
        .wr_en   (ctl.wr_reg),
        .wr_idx  (ir_q[RI_LSB +: IDX_W]),
        .wr_data (wr_data)
    );

    sbc_alu #(.DATA_W(DATA_W)) alu_i (
        .a   (a_q),
        .b   (bus),
        .sum (alu_sum)
    );

    // The shared bus: exactly one source per step.
    always_comb begin
        case (ctl.src)
            SRC_IP:  bus = {{PAD_W{1'b0}}, ip_q};
            SRC_IRA: bus = {{PAD_W{1'b0}}, ir_q[ADDR_W-1:0]};
            SRC_MDR: bus = mdr_q;
            SRC_REG: bus = rf_rd;
            SRC_C:   bus = c_q;
            default: bus = '0;
        endcase
    end

    // Destination write comes from the bus, or from the ALU bridge (two-bus add).
    assign wr_data = ctl.wr_from_alu ? alu_sum : bus;

    // Instruction pointer: jump load or post-read increment.
    always_ff @(posedge clk) begin
        if (!rst_n)          ip_q <= '0;
        else if (ctl.ld_ip)  ip_q <= bus[ADDR_W-1:0];
        else if (ctl.inc_ip) ip_q <= ip_q + 1'b1;
    end

    // Memory address latch.
    always_ff @(posedge clk) begin
        if (!rst_n)          mar_q <= '0;
        else if (ctl.ld_mar) mar_q <= bus[ADDR_W-1:0];
    end

    // Memory data latch: from memory on a read, from the bus before a write.
    always_ff @(posedge clk) begin
        if (!rst_n)              mdr_q <= '0;
        else if (ctl.ld_mdr_mem) mdr_q <= mem_rdata;
        else if (ctl.ld_mdr_bus) mdr_q <= bus;
    end

    // Instruction latch.
    always_ff @(posedge clk) begin
        if (!rst_n)         ir_q <= '0;
        else if (ctl.ld_ir) ir_q <= bus;
    end

    // ALU operand and result latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            c_q <= '0;
        end else begin
            if (ctl.ld_a) a_q <= bus;
            if (ctl.ld_c) c_q <= alu_sum;
        end
    end

    assign mem_addr  = mar_q;
    assign mem_wdata = mdr_q;
    assign mem_rd    = ctl.mem_rd;
    assign mem_wr    = ctl.mem_wr;

endmodule

// File: rtl/sbc_checker.sv
`timescale 1ns/1ps
// Protocol checks on the sequencer's bus and memory port.
// Assumes it is bound into sbus_cpu.
module sbc_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [5:0]        bus_sel,
    input logic              ld_mar,
    input logic              ld_mdr_bus,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr
);

    a_r9_one_bus_source: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(bus_sel));

    a_r10_no_rd_and_wr: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r10_read_after_mar: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> $past(ld_mar));

    a_r10_write_after_mdr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(ld_mdr_bus));

    a_r10_write_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $stable(mem_addr));

    a_r3_single_step_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

endmodule

bind sbus_cpu sbc_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .ld_mar     (ld_mar_w),
    .ld_mdr_bus (ld_mdr_bus_w),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_addr   (mem_addr)
);

// File: tb/sbus_cpu_tb_top.sv
`timescale 1ns/1ps
// Runs the one-bus and two-bus builds side by side against an
// instruction-level model; compares every memory event by step, address, data.
module sbus_cpu_tb_top;

    localparam int DW = 12;
    localparam int AW = 4;
    localparam int DEPTH = 16;
    localparam int MAXEV = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [AW-1:0] m_addr  [2];
    logic          m_rd    [2];
    logic          m_wr    [2];
    logic [DW-1:0] m_wdata [2];
    logic [DW-1:0] m_rdata [2];

    sbus_cpu #(.DATA_W(DW), .ADDR_W(AW), .NREG(4), .TWO_BUS(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .mem_addr(m_addr[0]), .mem_rd(m_rd[0]),
        .mem_wr(m_wr[0]), .mem_wdata(m_wdata[0]), .mem_rdata(m_rdata[0]));

    sbus_cpu #(.DATA_W(DW), .ADDR_W(AW), .NREG(4), .TWO_BUS(1'b1)) dut_fast_i (
        .clk(clk), .rst_n(rst_n), .mem_addr(m_addr[1]), .mem_rd(m_rd[1]),
        .mem_wr(m_wr[1]), .mem_wdata(m_wdata[1]), .mem_rdata(m_rdata[1]));

    // Bench memories: combinational read, write at the clock edge.
    logic [DW-1:0] mem [2][DEPTH];
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    assign m_rdata[0] = mem[0][m_addr[0]];
    assign m_rdata[1] = mem[1][m_addr[1]];
    always @(posedge clk) begin
        if (ld_en) begin
            mem[0][ld_addr] <= ld_data;
            mem[1][ld_addr] <= ld_data;
        end else begin
            if (m_wr[0]) mem[0][m_addr[0]] <= m_wdata[0];
            if (m_wr[1]) mem[1][m_addr[1]] <= m_wdata[1];
        end
    end

    // Recorded events.
    int            cyc;
    bit            mon_on = 1'b0;
    int            ev_n   [2];
    int            ev_cyc [2][MAXEV];
    bit            ev_wr  [2][MAXEV];
    logic [AW-1:0] ev_addr[2][MAXEV];
    logic [DW-1:0] ev_data[2][MAXEV];
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            cyc = cyc + 1;
            for (int k = 0; k < 2; k++) begin
                if ((m_rd[k] || m_wr[k]) && ev_n[k] < MAXEV) begin
                    ev_cyc[k][ev_n[k]]  = cyc;
                    ev_wr[k][ev_n[k]]   = m_wr[k];
                    ev_addr[k][ev_n[k]] = m_addr[k];
                    ev_data[k][ev_n[k]] = m_wdata[k];
                    ev_n[k] = ev_n[k] + 1;
                end
            end
        end
    end

    // Expected events.
    int            x_n   [2];
    int            x_cyc [2][MAXEV];
    bit            x_wr  [2][MAXEV];
    logic [AW-1:0] x_addr[2][MAXEV];
    logic [DW-1:0] x_data[2][MAXEV];
    string         x_tag [2][MAXEV];
    int            t_end [2];

    logic [DW-1:0] prog [DEPTH];
    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    function automatic logic [DW-1:0] enc(int op, int ri, int rj, int rk, int ad);
        return DW'((op << 9) | (ri << 7) | (rj << 5) | (rk << 3) | ad);
    endfunction

    function automatic logic [31:0] xs(logic [31:0] s);
        logic [31:0] v = s;
        v = v ^ (v << 13);
        v = v ^ (v >> 17);
        v = v ^ (v << 5);
        return v;
    endfunction

    task automatic push(int k, int c, bit w, int ad, logic [DW-1:0] d, string tg);
        if (x_n[k] < MAXEV) begin
            x_cyc[k][x_n[k]]  = c;
            x_wr[k][x_n[k]]   = w;
            x_addr[k][x_n[k]] = AW'(ad);
            x_data[k][x_n[k]] = d;
            x_tag[k][x_n[k]]  = tg;
            x_n[k] = x_n[k] + 1;
        end
    endtask

    // Instruction-level model; step 0 is the first step after reset release.
    task automatic model(int k, int n_instr);
        logic [DW-1:0] m [DEPTH];
        logic [DW-1:0] r [4];
        string rt [4];
        string prev = "R1";
        bit two = (k == 1);
        int ip = 0;
        int t = 0;
        bit wrapped = 1'b0;
        for (int i = 0; i < DEPTH; i++) m[i] = prog[i];
        for (int i = 0; i < 4; i++) begin r[i] = '0; rt[i] = "R5"; end
        x_n[k] = 0;
        for (int i = 0; i < n_instr; i++) begin
            logic [DW-1:0] w = m[ip];
            int op = int'(w[11:9]);
            int ri = int'(w[8:7]);
            int rj = int'(w[6:5]);
            int rk = int'(w[4:3]);
            int ad = int'(w[3:0]);
            push(k, t + 1, 1'b0, ip, '0, wrapped ? "R11" : prev);
            wrapped = (ip == DEPTH - 1);
            ip = (ip + 1) % DEPTH;
            case (op)
                1: begin
                    push(k, t + 5, 1'b0, ad, '0, "R4");
                    r[ri] = m[ad]; rt[ri] = "R4"; t = t + 7; prev = "R3";
                end
                2: begin
                    push(k, t + 6, 1'b1, ad, r[ri],
                         (rt[ri] == "R6") ? (two ? "R12" : "R6") : "R5");
                    m[ad] = r[ri]; t = t + 7; prev = "R5";
                end
                3: begin
                    r[ri] = DW'(r[rj] + r[rk]); rt[ri] = "R6";
                    t = t + (two ? 6 : 7); prev = two ? "R12" : "R6";
                end
                4: begin
                    ip = ad; wrapped = 1'b0; t = t + 5; prev = "R7";
                end
                default: begin
                    t = t + 4; prev = "R8";
                end
            endcase
        end
        t_end[k] = t;
    endtask

    task automatic compare(int k);
        int nrec = 0;
        for (int i = 0; i < ev_n[k]; i++) if (ev_cyc[k][i] < t_end[k]) nrec++;
        n_vec++;
        if (nrec != x_n[k]) begin
            n_bad++;
            $display("FAIL R2 dut%0d event count: actual %0d expected %0d", k, nrec, x_n[k]);
        end
        for (int i = 0; i < x_n[k] && i < nrec; i++) begin
            bit ok = (ev_cyc[k][i] == x_cyc[k][i]) && (ev_wr[k][i] == x_wr[k][i]) &&
                     (ev_addr[k][i] == x_addr[k][i]) &&
                     (!x_wr[k][i] || ev_data[k][i] == x_data[k][i]);
            n_vec++;
            if (!ok) begin
                n_bad++;
                $display("FAIL %s dut%0d event %0d: actual step %0d wr %0d addr %0d data %h, expected step %0d wr %0d addr %0d data %h",
                         x_tag[k][i], k, i, ev_cyc[k][i], ev_wr[k][i], ev_addr[k][i], ev_data[k][i],
                         x_cyc[k][i], x_wr[k][i], x_addr[k][i], x_data[k][i]);
            end
        end
    endtask

    task automatic run_prog(int n_instr);
        int tmax;
        rst_n  = 1'b0;
        mon_on = 1'b0;
        @(negedge clk);
        for (int i = 0; i < DEPTH; i++) begin
            ld_en = 1'b1; ld_addr = AW'(i); ld_data = prog[i];
            @(negedge clk);
        end
        ld_en = 1'b0;
        @(negedge clk);
        // R1: reset state at the port.
        for (int k = 0; k < 2; k++) begin
            n_vec++;
            if (m_rd[k] !== 1'b0 || m_wr[k] !== 1'b0 || m_addr[k] !== '0) begin
                n_bad++;
                $display("FAIL R1 dut%0d reset state: actual rd %b wr %b addr %0d, expected 0 0 0",
                         k, m_rd[k], m_wr[k], m_addr[k]);
            end
        end
        model(0, n_instr);
        model(1, n_instr);
        ev_n[0] = 0;
        ev_n[1] = 0;
        cyc = 0;
        tmax = (t_end[0] > t_end[1]) ? t_end[0] : t_end[1];
        #1;
        rst_n  = 1'b1;
        mon_on = 1'b1;
        repeat (tmax + 2) @(negedge clk);
        #1;
        mon_on = 1'b0;
        compare(0);
        compare(1);
    endtask

    initial begin
        logic [31:0] seed;
        // Loads, aliased and overflowing adds, stores, self-jump.
        for (int i = 0; i < DEPTH; i++) prog[i] = '0;
        prog[0]  = enc(1, 1, 0, 0, 14);
        prog[1]  = enc(1, 2, 0, 0, 15);
        prog[2]  = enc(3, 3, 1, 2, 0);
        prog[3]  = enc(2, 3, 0, 0, 13);
        prog[4]  = enc(3, 1, 1, 1, 0);
        prog[5]  = enc(2, 1, 0, 0, 12);
        prog[6]  = enc(3, 2, 2, 3, 0);
        prog[7]  = enc(2, 2, 0, 0, 11);
        prog[8]  = enc(4, 0, 0, 0, 8);
        prog[14] = 12'hFFF;
        prog[15] = 12'h002;
        run_prog(12);

        // R8 undefined opcodes then a store, R11 wrap back to 0.
        for (int i = 0; i < DEPTH; i++) prog[i] = '0;
        prog[0]  = enc(4, 0, 0, 0, 10);
        prog[9]  = 12'h5A5;
        prog[10] = enc(1, 1, 0, 0, 9);
        prog[11] = 12'hDBF;
        prog[12] = 12'hB8F;
        prog[13] = 12'h1F9;
        prog[14] = 12'hFFF;
        prog[15] = enc(2, 1, 0, 0, 8);
        run_prog(16);

        // Pseudo-random images: mixed opcodes, self-modifying code.
        seed = 32'h1234_5678;
        for (int s = 0; s < 12; s++) begin
            for (int i = 0; i < DEPTH; i++) begin
                seed = xs(seed);
                prog[i] = seed[DW-1:0];
            end
            run_prog(40);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual run still going, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule